// File: doc/BRIEF.md
# I2C Serial Clock Phase Generator

This block produces the serial clock for an I2C master. A 32-bit divider word sets the two halves of the clock period independently: the upper half-word gives the high-phase divisor and the lower half-word the low-phase divisor. Each phase lasts a whole number of eight-cycle units, and the hardware adds one unit to each divisor. Low and high can therefore be tuned separately to meet the bus minimum low time, the minimum high time and the data-hold limit, rather than sharing one symmetric setting.

Alongside the clock level the block gives three single-cycle strobes. One marks the first cycle of each low phase. One marks the first cycle of each high phase. One marks the midpoint of each low phase, where a shifter may change the data line. An enable input starts and stops the clock. While disabled, the clock rests high and all counting state is cleared. Framing, byte shifting and clock stretching belong to the logic around this block.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is asserted, and in every cycle after a cycle in which `en` was sampled low, `scl` is 1 and all three strobes are 0.
- R2: Each low phase, counted as consecutive cycles with `scl` at 0, lasts exactly 8*(DL+1) cycles, where DL is `div_cfg[15:0]` as latched for that period.
- R3: Each high phase that ends in a new low phase lasts exactly 8*(DH+1) cycles, where DH is `div_cfg[31:16]` as latched for that period.
- R4: The high divisor is taken from bits 31:16 of `div_cfg` and the low divisor from bits 15:0, so unequal values give unequal phase lengths.
- R5: `sda_stb` pulses exactly once per complete low phase, for one cycle, in the low cycle that follows 4*(DL+1) earlier low cycles (0-based index 4*(DL+1) counted from the first low cycle), and never while `scl` is 1.
- R6: `fall_stb` is 1 only in the first cycle of a low phase and `rise_stb` only in the first cycle of a high phase, each for one cycle.
- R7: When `en` is sampled high while the block is idle, the next cycle is the first cycle of a low phase (`scl` 0, `fall_stb` 1).
- R8: `div_cfg` is latched only on the clock edge that begins a low phase. A change made while a period is in progress has no effect until the next low phase.
- R9: When `en` drops during a phase, `scl` is 1 in the next cycle with no strobe. A later enable starts a fresh, full-length low phase.
- R10: At most one of the three strobes is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock run enable |
| div_cfg | input | 32 | Divider word: high divisor in 31:16, low divisor in 15:0 |
| scl | output | 1 | Serial clock level (registered) |
| sda_stb | output | 1 | Data-change point, mid low phase |
| rise_stb | output | 1 | First cycle of a high phase |
| fall_stb | output | 1 | First cycle of a low phase |

## Verification
All outputs follow one register stage. An enable sampled at a rising edge shows up as `fall_stb` and a low `scl` at the next falling-edge sample, and a disable shows up as a high `scl` at the same point. The bench drives inputs and samples outputs on the falling edge. It counts samples from the `fall_stb` sample (index 0): it expects `sda_stb` at index 4*(DL+1) and the first high sample, with `rise_stb`, at index 8*(DL+1). The high phase is timed the same way up to the next `fall_stb`. The divider word is changed one sample after the low phase starts, so the latched old value must still govern that whole period.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/sp_prescale.sv
// Sub-unit prescaler: counts input cycles within one divisor unit.
module sp_prescale #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [PRE_W-1:0] q,
  output logic             wrap
);
  logic [PRE_W-1:0] q_nxt;

  always_comb begin
    if (clr) q_nxt = '0;
    else     q_nxt = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign wrap = &q;
endmodule

// File: rtl/sp_unit_cnt.sv
// Unit counter: counts whole divisor units inside the current phase.
module sp_unit_cnt #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [DIV_W-1:0] q
);
  logic [DIV_W-1:0] q_nxt;
  logic             q_en;

  always_comb begin
    q_en  = clr | inc;
    q_nxt = clr ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/sp_phase_ctrl.sv
// Phase sequencer: idle/low/high state, divisor latch and strobe decode.
module sp_phase_ctrl
  import sp_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int PRE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [2*DIV_W-1:0] div_cfg,
  input  logic [PRE_W-1:0]   pre_q,
  input  logic               pre_wrap,
  input  logic [DIV_W-1:0]   unit_q,
  output logic               cnt_clr,
  output logic               scl,
  output logic               sda_stb,
  output logic               rise_stb,
  output logic               fall_stb
);
  localparam int POS_W = DIV_W + PRE_W;

  phase_e             st_q, st_nxt;
  logic [DIV_W-1:0]   lo_q, hi_q, lim;
  logic               load, phase_end, at_origin, scl_nxt;
  logic [POS_W-1:0]   pos, half_pos;
  logic [DIV_W:0]     lo_units;

  // next-state logic
  always_comb begin
    lim       = (st_q == PH_HIGH) ? hi_q : lo_q;
    phase_end = pre_wrap && (unit_q == lim);
    st_nxt    = st_q;
    unique case (st_q)
      PH_IDLE: st_nxt = en ? PH_LOW : PH_IDLE;
      PH_LOW:  st_nxt = !en ? PH_IDLE : (phase_end ? PH_HIGH : PH_LOW);
      PH_HIGH: st_nxt = !en ? PH_IDLE : (phase_end ? PH_LOW : PH_HIGH);
      default: st_nxt = PH_IDLE;
    endcase
    load    = en && ((st_q == PH_IDLE) || ((st_q == PH_HIGH) && phase_end));
    cnt_clr = !en || (st_q == PH_IDLE) || phase_end;
    scl_nxt = (st_nxt != PH_LOW);
  end

  // state and divisor registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE;
      scl  <= 1'b1;
    end else begin
      st_q <= st_nxt;
      scl  <= scl_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= div_cfg[DIV_W-1:0];
      hi_q <= div_cfg[2*DIV_W-1:DIV_W];
    end
  end

  // strobe decode from registered state and counters
  always_comb begin
    at_origin = (pre_q == '0) && (unit_q == '0);
    pos       = {unit_q, pre_q};
    lo_units  = {1'b0, lo_q} + 1'b1;
    half_pos  = POS_W'(lo_units) << (PRE_W - 1);
    fall_stb  = (st_q == PH_LOW)  && at_origin;
    rise_stb  = (st_q == PH_HIGH) && at_origin;
    sda_stb   = (st_q == PH_LOW)  && (pos == half_pos);
  end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int DIV_W = 16,
  parameter int PRE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [2*DIV_W-1:0] div_cfg,
  output logic               scl,
  output logic               sda_stb,
  output logic               rise_stb,
  output logic               fall_stb
);
  logic [PRE_W-1:0] pre_q;
  logic             pre_wrap;
  logic [DIV_W-1:0] unit_q;
  logic             cnt_clr;

  sp_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .q     (pre_q),
    .wrap  (pre_wrap)
  );

  sp_unit_cnt #(.DIV_W(DIV_W)) u_unit (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (pre_wrap),
    .q     (unit_q)
  );

  sp_phase_ctrl #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .div_cfg  (div_cfg),
    .pre_q    (pre_q),
    .pre_wrap (pre_wrap),
    .unit_q   (unit_q),
    .cnt_clr  (cnt_clr),
    .scl      (scl),
    .sda_stb  (sda_stb),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int PRE_W = 3
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl,
  input logic sda_stb,
  input logic rise_stb,
  input logic fall_stb
);
  logic [23:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   low_run <= '0;
    else if (scl) low_run <= '0;
    else          low_run <= low_run + 1'b1;
  end

  AST_IDLE_REST: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl && !sda_stb && !rise_stb && !fall_stb)); // R1
  AST_LOW_WHOLE_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (low_run != '0) && (low_run[PRE_W-1:0] == '0)); // R2
  AST_SDA_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sda_stb |-> !scl); // R5
  AST_FALL_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> !scl); // R6
  AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl) && $past(en)) |-> rise_stb); // R6
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> (fall_stb && !scl)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sda_stb, rise_stb, fall_stb})); // R10
endmodule

bind scl_phase_gen sp_checker #(.PRE_W(PRE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .scl      (scl),
  .sda_stb  (sda_stb),
  .rise_stb (rise_stb),
  .fall_stb (fall_stb)
);

// File: tb/sim_scl_phase_gen.sv
module sim_scl_phase_gen;
  localparam int CLK_PERIOD = 10;
  localparam int GUARD      = 700000;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [31:0] div_cfg;
  logic        scl, sda_stb, rise_stb, fall_stb;

  int checks;
  int errors;

  scl_phase_gen u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .div_cfg  (div_cfg),
    .scl      (scl),
    .sda_stb  (sda_stb),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // starts from idle with the given divisors; returns at the first low sample
  task automatic start(input int lo, input int hi);
    en      = 1'b0;
    div_cfg = {hi[15:0], lo[15:0]};
    step(); step();
    en = 1'b1;
    step();
    chk(fall_stb && !scl, "R7 first cycle after enable is low with fall", {scl, fall_stb}, 1);
  endtask

  // called at the fall sample; returns at the first high sample
  task automatic meas_low(input int lo, input string tag);
    int idx = 0, nsda = 0, pos = -1, stray = 0;
    while (!scl && idx < GUARD) begin
      if (sda_stb) begin nsda++; pos = idx; end
      if (rise_stb || (idx > 0 && fall_stb)) stray++;
      idx++;
      step();
    end
    chk(idx == 8*(lo+1), {"R2 low length ", tag}, idx, 8*(lo+1));
    chk(nsda == 1 && pos == 4*(lo+1), {"R5 data strobe position ", tag}, pos, 4*(lo+1));
    chk(rise_stb && stray == 0, {"R6 rise strobe at first high cycle ", tag}, stray, 0);
  endtask

  // called at the first high sample; returns at the next fall sample
  task automatic meas_high(input int hi, input string tag);
    int idx = 0, stray = 0;
    while (scl && idx < GUARD) begin
      if (sda_stb || fall_stb || (idx > 0 && rise_stb)) stray++;
      idx++;
      step();
    end
    chk(idx == 8*(hi+1), {"R3 high length ", tag}, idx, 8*(hi+1));
    chk(fall_stb && stray == 0, {"R6 fall strobe at next low ", tag}, stray, 0);
  endtask

  task automatic t_reset();
    rst_n   = 1'b0;
    en      = 1'b1;
    div_cfg = '0;
    step(); step();
    chk(scl && !sda_stb && !rise_stb && !fall_stb, "R1 outputs during reset",
        {scl, sda_stb, rise_stb, fall_stb}, 8);
    en = 1'b0;
    step();
    rst_n = 1'b1;
    step(); step();
    chk(scl && !sda_stb && !rise_stb && !fall_stb, "R1 outputs idle after reset",
        {scl, sda_stb, rise_stb, fall_stb}, 8);
  endtask

  task automatic t_period(input int lo, input int hi, input string tag);
    start(lo, hi);
    meas_low(lo, tag);
    meas_high(hi, tag);
    meas_low(lo, tag);
    meas_high(hi, tag);
  endtask

  // R4: unequal halves prove which field feeds which phase
  task automatic t_fields();
    t_period(3, 0, "R4 low field bits 15:0");
    t_period(0, 6, "R4 high field bits 31:16");
  endtask

  // R8: change divisors after the period has started
  task automatic t_midwrite();
    start(2, 1);
    div_cfg = 32'h0000_0000;
    meas_low(2, "R8 old low kept");
    div_cfg = 32'h0004_0001;
    meas_high(1, "R8 old high kept");
    meas_low(1, "R8 new low applied");
    meas_high(4, "R8 new high applied");
  endtask

  // R9: disable inside a phase and restart
  task automatic t_disable();
    int bad = 0;
    start(3, 3);
    repeat (5) step();
    en = 1'b0;
    step();
    chk(scl && !sda_stb && !rise_stb && !fall_stb, "R9 low phase cut by disable",
        {scl, sda_stb, rise_stb, fall_stb}, 8);
    for (int i = 0; i < 10; i++) begin
      if (!scl || sda_stb || rise_stb || fall_stb) bad++;
      step();
    end
    chk(bad == 0, "R1 idle while disabled", bad, 0);
    en = 1'b1;
    step();
    chk(fall_stb && !scl, "R9 restart begins with low", {scl, fall_stb}, 1);
    meas_low(3, "R9 full low after restart");
    en = 1'b0;
    step();
    chk(scl && !sda_stb && !rise_stb && !fall_stb, "R9 high phase cut by disable",
        {scl, sda_stb, rise_stb, fall_stb}, 8);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    t_reset();
    t_period(0, 0, "div 0/0");
    t_period(1, 2, "div 1/2");
    t_period(5, 4, "div 5/4");
    t_fields();
    t_midwrite();
    t_disable();
    t_period(300, 200, "div 300/200");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule